// File: doc/BRIEF.md
# Calendar Timekeeping Core with Update Warning

This block keeps wall-clock time and a calendar date in a small byte-wide register file. Each pulse on a one-second tick starts an update. A status flag rises first. After a programmable warning window, seconds, minutes, hours, day of week, day of month, month and year all advance together, with ripple carry from seconds up to the year. The flag stays high for a further programmable settling period. When it falls, a one-cycle completion pulse is emitted for a neighbouring interrupt unit.

A processor reaches every register through a single-cycle write strobe and a combinational read path. A control register selects the field encoding (packed BCD or plain binary) and the hour encoding (24-hour, or 12-hour with an afternoon marker in bit 7). It also holds a freeze bit that suspends all updates while software loads a new time. A host reading the time polls the status flag, and starts its reads only while the flag is low.

Top module: `rtc_calendar_core`

## Requirements
- R1: The time fields sit at indices seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8 and year 9, and each can be written and read back. Index 13 reads 0x80. Indices 1, 3, 5 and 12 read 0 and ignore writes. After reset the registers hold 00:00:00, day of week 1, date 1/1, year 0 and control 0x02.
- R2: Bit 7 of index 10 is the update flag. It goes high on the first clock edge after an accepted tick and stays high for exactly WARN_CYC+UPD_CYC cycles. Bits 6:0 of index 10 are plain storage, and a host write to bit 7 has no effect.
- R3: The time fields change exactly once per update, on the edge WARN_CYC cycles after the edge that accepted the tick. They change at no other time except through a host write.
- R4: `upd_done_o` is high for exactly one cycle, the first cycle in which the update flag is low again.
- R5: While bit 7 of index 11 (freeze) is 1, ticks are ignored and the flag stays low. Setting freeze during an update abandons that update: the time does not change and no completion pulse appears.
- R6: A tick that arrives while the update flag is high is ignored, and no second update follows.
- R7: Bit 2 of index 11 set to 1 selects binary fields; set to 0 it selects packed BCD (tens in bits 7:4, units in bits 3:0).
- R8: Seconds and minutes wrap from 59 to 0 with a carry. In 24-hour mode (bit 1 of index 11 = 1), hours wrap from 23 to 0 with a carry into the date.
- R9: In 12-hour mode, hours run 1 to 12 and bit 7 of the hours register marks PM. 11 AM goes to 12 PM, 12 PM goes to 1 PM, and 11 PM goes to 12 AM with a carry into the date.
- R10: Day of week counts 1 to 7 and wraps to 1. Day of month wraps to 1 after the month's last day, and February has 29 days when the year is divisible by 4. Month wraps from 12 to 1 and year from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Register index for reads and writes |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| upd_done_o | output | 1 | One-cycle pulse when an update has finished |

## Verification
The update flag is due one edge after the tick is sampled, so the bench reads index 10 half a cycle after that edge. The seconds register is read once in the cycle before edge WARN_CYC, where it must still hold the old value, and again just after that edge, where it must hold the new one. The flag and `upd_done_o` are sampled in the cycle before edge WARN_CYC+UPD_CYC and in the cycle after it, and the pulse is checked to be gone one cycle later. Full register compares are made only once the flag is low again. All sampling is done on the falling clock edge, so every read sits between two active edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] IX_SEC  = 4'd0;
    localparam logic [AW-1:0] IX_MIN  = 4'd2;
    localparam logic [AW-1:0] IX_HR   = 4'd4;
    localparam logic [AW-1:0] IX_DOW  = 4'd6;
    localparam logic [AW-1:0] IX_DOM  = 4'd7;
    localparam logic [AW-1:0] IX_MON  = 4'd8;
    localparam logic [AW-1:0] IX_YR   = 4'd9;
    localparam logic [AW-1:0] IX_CTLA = 4'd10;
    localparam logic [AW-1:0] IX_CTLB = 4'd11;
    localparam logic [AW-1:0] IX_STAT = 4'd13;

    localparam int BIT_FREEZE = 7;
    localparam int BIT_BIN    = 2;
    localparam int BIT_H24    = 1;

    localparam logic [DW-1:0] STAT_VALID = 8'h80;
    localparam logic [DW-1:0] CTL_RESET  = 8'h02;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hr;
        logic [DW-1:0] dow;
        logic [DW-1:0] dom;
        logic [DW-1:0] mon;
        logic [DW-1:0] yr;
    } cal_t;

    typedef enum logic [1:0] {PH_IDLE, PH_WARN, PH_BUSY} phase_e;

    // Field value as a plain number, whatever the encoding
    function automatic logic [DW-1:0] to_bin(input logic [DW-1:0] v, input logic bin_mode);
        return bin_mode ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
    endfunction

    // Plain number back to the selected encoding
    function automatic logic [DW-1:0] from_bin(input logic [DW-1:0] b, input logic bin_mode);
        logic [DW-1:0] tens;
        logic [DW-1:0] ones;
        tens = b / 8'd10;
        ones = b % 8'd10;
        return bin_mode ? b : {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [DW-1:0] mon_i,
    input  logic [DW-1:0] yr_i,
    output logic [DW-1:0] days_o
);
    logic leap;
    assign leap = (yr_i[1:0] == 2'b00);

    always_comb begin
        case (mon_i)
            8'd2:                   days_o = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: days_o = 8'd30;
            default:                days_o = 8'd31;
        endcase
    end
endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_pkg::*;
(
    input  cal_t cur_i,
    input  logic bin_i,
    input  logic h24_i,
    output cal_t nxt_o
);
    logic [DW-1:0] mon_b;
    logic [DW-1:0] yr_b;
    logic [DW-1:0] dim;

    assign mon_b = to_bin(cur_i.mon, bin_i);
    assign yr_b  = to_bin(cur_i.yr, bin_i);

    rtc_month_len u_mlen (
        .mon_i  (mon_b),
        .yr_i   (yr_b),
        .days_o (dim)
    );

    logic          carry;
    logic [DW-1:0] s_v, m_v, hh, h24, h12, h_enc, w_v, d_v, mo_v, y_v;

    always_comb begin
        nxt_o = cur_i;
        carry = 1'b0;
        m_v   = '0;
        hh    = '0;
        h24   = '0;
        h12   = '0;
        h_enc = '0;
        w_v   = '0;
        d_v   = '0;
        mo_v  = '0;
        y_v   = '0;

        // seconds always advance
        s_v = to_bin(cur_i.sec, bin_i);
        if (s_v >= 8'd59) begin
            s_v   = '0;
            carry = 1'b1;
        end else begin
            s_v = s_v + 8'd1;
        end
        nxt_o.sec = from_bin(s_v, bin_i);

        if (carry) begin
            m_v = to_bin(cur_i.min, bin_i);
            if (m_v >= 8'd59) begin
                m_v = '0;
            end else begin
                m_v   = m_v + 8'd1;
                carry = 1'b0;
            end
            nxt_o.min = from_bin(m_v, bin_i);
        end

        if (carry) begin
            hh = to_bin({1'b0, cur_i.hr[6:0]}, bin_i);
            if (h24_i)              h24 = hh;
            else if (hh == 8'd12)   h24 = cur_i.hr[7] ? 8'd12 : 8'd0;
            else                    h24 = cur_i.hr[7] ? hh + 8'd12 : hh;
            if (h24 >= 8'd23) begin
                h24 = '0;
            end else begin
                h24   = h24 + 8'd1;
                carry = 1'b0;
            end
            if (h24_i) begin
                nxt_o.hr = from_bin(h24, bin_i);
            end else begin
                if (h24 == 8'd0)      h12 = 8'd12;
                else if (h24 > 8'd12) h12 = h24 - 8'd12;
                else                  h12 = h24;
                h_enc    = from_bin(h12, bin_i);
                nxt_o.hr = {(h24 >= 8'd12), h_enc[6:0]};
            end
        end

        if (carry) begin
            w_v = to_bin(cur_i.dow, bin_i);
            w_v = (w_v >= 8'd7) ? 8'd1 : w_v + 8'd1;
            nxt_o.dow = from_bin(w_v, bin_i);

            d_v = to_bin(cur_i.dom, bin_i);
            if (d_v >= dim) begin
                d_v = 8'd1;
            end else begin
                d_v   = d_v + 8'd1;
                carry = 1'b0;
            end
            nxt_o.dom = from_bin(d_v, bin_i);
        end

        if (carry) begin
            mo_v = mon_b;
            if (mo_v >= 8'd12) begin
                mo_v = 8'd1;
            end else begin
                mo_v  = mo_v + 8'd1;
                carry = 1'b0;
            end
            nxt_o.mon = from_bin(mo_v, bin_i);
        end

        if (carry) begin
            y_v = (yr_b >= 8'd99) ? 8'd0 : yr_b + 8'd1;
            nxt_o.yr = from_bin(y_v, bin_i);
        end
    end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_pkg::*;
#(
    parameter int WARN_CYC = 8,
    parameter int UPD_CYC  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic inhibit_i,
    output logic busy_o,
    output logic advance_o,
    output logic done_o
);
    localparam int MAXC = (WARN_CYC > UPD_CYC) ? WARN_CYC : UPD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic adv;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        adv        = 1'b0;
        case (seq_q.ph)
            PH_IDLE: if (tick_i) begin
                seq_d.ph  = PH_WARN;
                seq_d.cnt = CW'(WARN_CYC - 1);
            end
            PH_WARN: if (seq_q.cnt == '0) begin
                adv       = 1'b1;
                seq_d.ph  = PH_BUSY;
                seq_d.cnt = CW'(UPD_CYC - 1);
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
            PH_BUSY: if (seq_q.cnt == '0) begin
                seq_d.ph   = PH_IDLE;
                seq_d.done = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
        if (inhibit_i) begin
            seq_d.ph   = PH_IDLE;
            seq_d.cnt  = '0;
            seq_d.done = 1'b0;
            adv        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy_o    = (seq_q.ph != PH_IDLE);
    assign advance_o = adv;
    assign done_o    = seq_q.done;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int WARN_CYC = 8,
    parameter int UPD_CYC  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          upd_done_o
);
    typedef struct packed {
        cal_t          tm;
        logic [6:0]    a_lo;
        logic [DW-1:0] ctl;
    } regs_t;

    regs_t regs_d, regs_q;
    cal_t  tm_next;
    logic  uip, advance, inhibit;

    // freeze acts on the same edge that writes it
    assign inhibit = regs_q.ctl[BIT_FREEZE] |
                     (wr_en_i && addr_i == IX_CTLB && wr_data_i[BIT_FREEZE]);

    rtc_update_seq #(.WARN_CYC(WARN_CYC), .UPD_CYC(UPD_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .inhibit_i (inhibit),
        .busy_o    (uip),
        .advance_o (advance),
        .done_o    (upd_done_o)
    );

    rtc_time_step u_step (
        .cur_i (regs_q.tm),
        .bin_i (regs_q.ctl[BIT_BIN]),
        .h24_i (regs_q.ctl[BIT_H24]),
        .nxt_o (tm_next)
    );

    always_comb begin
        regs_d = regs_q;
        if (advance) regs_d.tm = tm_next;
        if (wr_en_i) begin
            case (addr_i)
                IX_SEC:  regs_d.tm.sec = wr_data_i;
                IX_MIN:  regs_d.tm.min = wr_data_i;
                IX_HR:   regs_d.tm.hr  = wr_data_i;
                IX_DOW:  regs_d.tm.dow = wr_data_i;
                IX_DOM:  regs_d.tm.dom = wr_data_i;
                IX_MON:  regs_d.tm.mon = wr_data_i;
                IX_YR:   regs_d.tm.yr  = wr_data_i;
                IX_CTLA: regs_d.a_lo   = wr_data_i[6:0];
                IX_CTLB: regs_d.ctl    = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.tm   <= '{sec: 8'd0, min: 8'd0, hr: 8'd0, dow: 8'd1,
                             dom: 8'd1, mon: 8'd1, yr: 8'd0};
            regs_q.a_lo <= '0;
            regs_q.ctl  <= CTL_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (addr_i)
            IX_SEC:  rd_data_o = regs_q.tm.sec;
            IX_MIN:  rd_data_o = regs_q.tm.min;
            IX_HR:   rd_data_o = regs_q.tm.hr;
            IX_DOW:  rd_data_o = regs_q.tm.dow;
            IX_DOM:  rd_data_o = regs_q.tm.dom;
            IX_MON:  rd_data_o = regs_q.tm.mon;
            IX_YR:   rd_data_o = regs_q.tm.yr;
            IX_CTLA: rd_data_o = {uip, regs_q.a_lo};
            IX_CTLB: rd_data_o = regs_q.ctl;
            IX_STAT: rd_data_o = STAT_VALID;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
    import rtc_pkg::*;
#(
    parameter int WARN_CYC = 8,
    parameter int UPD_CYC  = 64
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic wr_en_i,
    input logic upd_done_o,
    input logic uip,
    input logic set_bit,
    input cal_t tm
);
    localparam int SPAN = WARN_CYC + UPD_CYC;

    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_len <= '0;
        else if (uip) run_len <= run_len + 1'b1;
        else          run_len <= '0;
    end

    // R2: flag never stays up longer than the full span
    p_uip_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> (run_len < 32'(SPAN)));

    // R2: flag only rises after a sampled tick with freeze clear
    p_uip_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> ($past(tick_i) && !$past(set_bit)));

    // R3: time moves only during an update or by a host write
    p_time_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$past(uip)) |-> $stable(tm));

    // R4: completion pulse follows a full-length flag window
    p_done_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |-> (!uip && $past(uip) && run_len == 32'(SPAN)));

    // R4: pulse is one cycle wide
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |=> !upd_done_o);

    // R5: freeze keeps the flag down
    p_freeze_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_bit |-> !uip);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(
    .WARN_CYC (WARN_CYC),
    .UPD_CYC  (UPD_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .upd_done_o (upd_done_o),
    .uip        (uip),
    .set_bit    (regs_q.ctl[7]),
    .tm         (regs_q.tm)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int U = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       upd_done_o;

    int n_chk = 0, n_fail = 0, n_done = 0;
    int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;
    bit m_bin, m_24;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_core #(.WARN_CYC(W), .UPD_CYC(U)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .upd_done_o(upd_done_o)
    );

    always @(posedge clk) if (upd_done_o) n_done++;

    function automatic logic [7:0] enc(int v, bit bin);
        logic [3:0] t, o;
        t = 4'(v / 10);
        o = 4'(v % 10);
        return bin ? 8'(v) : {t, o};
    endfunction

    function automatic logic [7:0] enc_hr(int h, bit bin, bit h24);
        int h12;
        logic [7:0] e;
        if (h24) return enc(h, bin);
        h12 = (h == 0) ? 12 : (h > 12 ? h - 12 : h);
        e = enc(h12, bin);
        return {(h >= 12), e[6:0]};
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_mi++;
        if (m_mi < 60) return;
        m_mi = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0;
        m_w = (m_w == 7) ? 1 : m_w + 1;
        m_d++;
        if (m_d <= dim(m_mo, m_y)) return;
        m_d = 1; m_mo++;
        if (m_mo <= 12) return;
        m_mo = 1;
        m_y = (m_y == 99) ? 0 : m_y + 1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic load_time();
        logic [7:0] mode;
        mode = {5'b0, m_bin, m_24, 1'b0};
        wr(4'd11, mode | 8'h80);
        wr(4'd0, enc(m_s, m_bin));
        wr(4'd2, enc(m_mi, m_bin));
        wr(4'd4, enc_hr(m_h, m_bin, m_24));
        wr(4'd6, enc(m_w, m_bin));
        wr(4'd7, enc(m_d, m_bin));
        wr(4'd8, enc(m_mo, m_bin));
        wr(4'd9, enc(m_y, m_bin));
        wr(4'd11, mode);
    endtask

    task automatic check_all(string req);
        logic [7:0] d;
        rd(4'd0, d); chk(req, d, enc(m_s, m_bin));
        rd(4'd2, d); chk(req, d, enc(m_mi, m_bin));
        rd(4'd4, d); chk(req, d, enc_hr(m_h, m_bin, m_24));
        rd(4'd6, d); chk(req, d, enc(m_w, m_bin));
        rd(4'd7, d); chk(req, d, enc(m_d, m_bin));
        rd(4'd8, d); chk(req, d, enc(m_mo, m_bin));
        rd(4'd9, d); chk(req, d, enc(m_y, m_bin));
    endtask

    // one full update; model steps; timing checks along the way
    task automatic do_tick(bit extra);
        logic [7:0] d, old_s;
        int done0;
        old_s = enc(m_s, m_bin);
        done0 = n_done;
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        model_step();
        rd(4'd10, d); chk("R2 flag rises", d & 8'h80, 8'h80);
        repeat (W - 1) @(negedge clk);
        rd(4'd0, d); chk("R3 before advance", d, old_s);
        @(negedge clk);
        rd(4'd0, d); chk("R3 at advance", d, enc(m_s, m_bin));
        @(negedge clk);
        if (extra) tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        repeat (U - 3) @(negedge clk);
        rd(4'd10, d); chk("R2 flag held", d & 8'h80, 8'h80);
        chk("R4 no early pulse", 8'(upd_done_o), 8'h00);
        @(negedge clk);
        rd(4'd10, d); chk("R2 flag falls", d & 8'h80, 8'h00);
        chk("R4 pulse", 8'(upd_done_o), 8'h01);
        @(negedge clk);
        chk("R4 pulse width", 8'(upd_done_o), 8'h00);
        repeat (3) @(negedge clk);
        rd(4'd10, d);
        chk(extra ? "R6 late tick ignored" : "R2 idle", d & 8'h80, 8'h00);
        chk("R4 one pulse", 8'(n_done - done0), 8'h01);
    endtask

    task automatic set_model(int h, int mi, int s, int w, int d, int mo, int y,
                             bit bin, bit h24);
        m_h = h; m_mi = mi; m_s = s; m_w = w; m_d = d; m_mo = mo; m_y = y;
        m_bin = bin; m_24 = h24;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int seed_use;
        seed_use = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and fixed indices
        set_model(0, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        check_all("R1 reset");
        rd(4'd11, d); chk("R1 reset ctl", d, 8'h02);
        rd(4'd10, d); chk("R1 reset flag", d, 8'h00);
        rd(4'd13, d); chk("R1 valid", d, 8'h80);
        wr(4'd1, 8'h5a); rd(4'd1, d); chk("R1 unused idx", d, 8'h00);
        wr(4'd12, 8'hff); rd(4'd12, d); chk("R1 idx 12", d, 8'h00);

        // R2 low bits stored, flag bit not writable
        wr(4'd10, 8'hff); rd(4'd10, d); chk("R2 ctl a write", d, 8'h7f);

        // R10 R8 R7 full rollover, BCD 24h, with a late tick (R6)
        set_model(23, 59, 59, 7, 31, 12, 99, 1'b0, 1'b1);
        load_time(); check_all("R1 readback");
        do_tick(1'b1); check_all("R10 year rollover");
        // binary leap February
        set_model(23, 59, 59, 3, 28, 2, 24, 1'b1, 1'b1);
        load_time(); do_tick(1'b0); check_all("R10 leap feb 28");
        set_model(23, 59, 59, 3, 29, 2, 24, 1'b1, 1'b1);
        load_time(); do_tick(1'b0); check_all("R10 leap feb 29");
        set_model(23, 59, 59, 3, 28, 2, 23, 1'b0, 1'b1);
        load_time(); do_tick(1'b0); check_all("R10 plain feb");
        set_model(23, 59, 59, 4, 30, 4, 5, 1'b0, 1'b1);
        load_time(); do_tick(1'b0); check_all("R10 30-day month");
        // R9 12-hour transitions
        set_model(11, 59, 59, 2, 10, 6, 10, 1'b0, 1'b0);
        load_time(); do_tick(1'b0); check_all("R9 11AM to 12PM");
        rd(4'd4, d); chk("R9 noon code", d, 8'h92);
        set_model(12, 59, 59, 2, 10, 6, 10, 1'b0, 1'b0);
        load_time(); do_tick(1'b0); check_all("R9 12PM to 1PM");
        rd(4'd4, d); chk("R9 1PM code", d, 8'h81);
        set_model(23, 59, 59, 2, 10, 6, 10, 1'b1, 1'b0);
        load_time(); do_tick(1'b0); check_all("R9 11PM to 12AM");
        rd(4'd4, d); chk("R9 midnight code", d, 8'h0c);
        // R7 binary seconds encoding
        set_model(5, 6, 41, 1, 2, 3, 4, 1'b1, 1'b1);
        load_time(); do_tick(1'b0);
        rd(4'd0, d); chk("R7 binary sec", d, 8'd42);

        // R5 freeze blocks ticks
        begin
            int dn;
            dn = n_done;
            wr(4'd11, 8'h86);
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            rd(4'd10, d); chk("R5 frozen flag", d & 8'h80, 8'h00);
            repeat (W + U + 2) @(negedge clk);
            check_all("R5 frozen time");
            // abort an update in progress
            wr(4'd11, 8'h06);
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            wr(4'd11, 8'h86);
            rd(4'd10, d); chk("R5 abort flag", d & 8'h80, 8'h00);
            repeat (W + U + 2) @(negedge clk);
            check_all("R5 abort time");
            chk("R5 no pulse", 8'(n_done - dn), 8'h00);
            wr(4'd11, 8'h06);
        end

        // random sweep, biased toward wrap points
        for (int i = 0; i < 40; i++) begin
            int mo, y;
            mo = 1 + int'($urandom % 12);
            y = int'($urandom % 100);
            set_model(($urandom % 2) ? 23 - int'($urandom % 2) * 12 : int'($urandom % 24),
                      ($urandom % 2) ? 59 : int'($urandom % 60),
                      ($urandom % 3) ? 59 : int'($urandom % 60),
                      1 + int'($urandom % 7),
                      ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % 28),
                      mo, y, 1'($urandom % 2), 1'($urandom % 2));
            load_time();
            do_tick(1'($urandom % 2));
            check_all(m_24 ? "R8 random" : "R9 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule